// File: doc/BRIEF.md
# Debug Register Access Response Filter

This block stands between three requesters and a bank of debug registers. The requesters are an external debug port, a coprocessor-style instruction port and a memory-mapped bus port. Each of them issues accesses that carry a 10-bit register number, a read/write flag and write data. For every access the block picks one outcome: pass it on to the register bank, finish it locally with an error, finish it locally as a reserved register (reads give zero, writes are dropped), or report an undefined-instruction condition back to the coprocessor port.

The outcome depends on several things. The first is whether the debug logic has power. In a split-domain build that follows the debug domain; in a single-domain build it follows the processor. The second is a software-access enable. The third is whether the register number falls inside one of the two implementation-defined windows. The last is which port made the access. A baseline coprocessor mode input turns off the window filtering completely. When more than one port asks in the same cycle, the block serves one of them in a fixed priority order, so the bank sees at most one access per cycle.

Top module: `dbg_access_filter`

## Requirements
- R1: The debug logic counts as unpowered when `single_domain`=1 and `core_pwr_on`=0, or when `single_domain`=0 and `dbg_pwr_on`=0. In any other state it counts as powered.
- R2: An access accepted while the debug logic is unpowered is not forwarded. On the memory-mapped and external ports it completes with status 01 (error). On the coprocessor port the block also returns 01, but that outcome carries no meaning.
- R3: Register numbers 512..575 and 928..959 make up the implementation-defined windows. Numbers 512..515 (IMPL_COUNT=4 starting at 512) are implemented. Every other number in the windows is reserved, and every number outside the windows is an ordinary register.
- R4: With `sw_access_en`=0, a powered memory-mapped access to a window register completes with status 01 and is not forwarded.
- R5: With `sw_access_en`=0, a powered coprocessor access to a window register completes with status 10 (undefined) and is not forwarded.
- R6: With `sw_access_en`=0 and the default EXT_FWD_LOCKED=1, a powered external access to a window register is handled as if software access were enabled.
- R7: With `baseline_cp`=1, no register is treated as a window register. Every powered access is forwarded and completes with status 00.
- R8: An access to a reserved register that is not otherwise blocked completes with status 00 and read data 0, and it never reaches the bank.
- R9: A forwarded access puts its register number, write flag and write data on the bank port with `bank_valid`=1 in the cycle it is accepted. A forwarded read returns `bank_rdata` from that cycle with status 00, and a forwarded write returns data 0.
- R10: Status codes are 00 OK, 01 error and 10 undefined. The response comes on the requesting port as a one-cycle `*_rsp_valid` pulse on the clock edge after the accept cycle, which is the cycle where valid and ready are both high.
- R11: Priority runs external, then coprocessor, then memory-mapped. A port's ready is high only when no port above it is asserting valid, so at most one access is accepted per cycle.
- R12: The power, enable and baseline inputs are sampled only in the accept cycle. A change after acceptance does not alter that access's response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| dbg_pwr_on | input | 1 | Debug power domain on |
| core_pwr_on | input | 1 | Processor power on |
| single_domain | input | 1 | Single power domain build |
| sw_access_en | input | 1 | Software access enable (0 = locked out) |
| baseline_cp | input | 1 | Baseline coprocessor mode, window filtering off |
| ext_req_valid | input | 1 | External port request valid |
| ext_req_ready | output | 1 | External port request ready |
| ext_req_regnum | input | 10 | External port register number |
| ext_req_write | input | 1 | External port write flag |
| ext_req_wdata | input | 32 | External port write data |
| ext_rsp_valid | output | 1 | External port response valid |
| ext_rsp_status | output | 2 | External port response status |
| ext_rsp_rdata | output | 32 | External port read data |
| cp_req_valid | input | 1 | Coprocessor port request valid |
| cp_req_ready | output | 1 | Coprocessor port request ready |
| cp_req_regnum | input | 10 | Coprocessor port register number |
| cp_req_write | input | 1 | Coprocessor port write flag |
| cp_req_wdata | input | 32 | Coprocessor port write data |
| cp_rsp_valid | output | 1 | Coprocessor port response valid |
| cp_rsp_status | output | 2 | Coprocessor port response status |
| cp_rsp_rdata | output | 32 | Coprocessor port read data |
| mm_req_valid | input | 1 | Memory-mapped port request valid |
| mm_req_ready | output | 1 | Memory-mapped port request ready |
| mm_req_regnum | input | 10 | Memory-mapped port register number |
| mm_req_write | input | 1 | Memory-mapped port write flag |
| mm_req_wdata | input | 32 | Memory-mapped port write data |
| mm_rsp_valid | output | 1 | Memory-mapped port response valid |
| mm_rsp_status | output | 2 | Memory-mapped port response status |
| mm_rsp_rdata | output | 32 | Memory-mapped port read data |
| bank_valid | output | 1 | Access forwarded to register bank |
| bank_regnum | output | 10 | Forwarded register number |
| bank_write | output | 1 | Forwarded write flag |
| bank_wdata | output | 32 | Forwarded write data |
| bank_rdata | input | 32 | Register bank read data (same cycle) |

## Verification
The outcome selection is driven through a full sweep. It covers every port, all eight combinations of the three power inputs, both enable levels, both baseline levels, and reads and writes to numbers just inside and just outside each window and each edge of the implemented range. The power sweep separates the two power-down sources from each other. The enable sweep with a fixed register shows the three ports diverging from one another. The edge numbers 511/512, 515/516, 575/576, 927/928 and 959/960 each catch an off-by-one in the window or implemented-range decoding. Separate patterns with all three ports asserting valid together check the serving order, and an enable change after acceptance shows that inputs are sampled at accept time.

// File: rtl/dbgf_pkg.sv
package dbgf_pkg;

   localparam int NUM_PORTS = 3;

   // port index doubles as priority rank: lower index wins
   localparam logic [1:0] PORT_EXT = 2'd0;
   localparam logic [1:0] PORT_CP  = 2'd1;
   localparam logic [1:0] PORT_MM  = 2'd2;

   typedef enum logic [1:0] {
      RSP_OK    = 2'b00,
      RSP_ERR   = 2'b01,
      RSP_UNDEF = 2'b10
   } rsp_e;

   typedef enum logic [1:0] {
      CLS_PLAIN = 2'd0,
      CLS_IMPL  = 2'd1,
      CLS_RSVD  = 2'd2
   } reg_cls_e;

   typedef enum logic [1:0] {
      ACT_FWD  = 2'd0,
      ACT_ZERO = 2'd1,
      ACT_FAIL = 2'd2
   } act_e;

endpackage

// File: rtl/dbgf_classify.sv
module dbgf_classify
   import dbgf_pkg::*;
#(
   parameter int REG_W      = 10,
   parameter int WIN0_LO    = 512,
   parameter int WIN0_HI    = 575,
   parameter int WIN1_LO    = 928,
   parameter int WIN1_HI    = 959,
   parameter int IMPL_LO    = 512,
   parameter int IMPL_COUNT = 4
) (
   input  logic [REG_W-1:0] regnum,
   input  logic             baseline,
   output reg_cls_e         cls
);

   localparam logic [REG_W-1:0] W0L = REG_W'(WIN0_LO);
   localparam logic [REG_W-1:0] W0H = REG_W'(WIN0_HI);
   localparam logic [REG_W-1:0] W1L = REG_W'(WIN1_LO);
   localparam logic [REG_W-1:0] W1H = REG_W'(WIN1_HI);

   logic in_win;
   logic impl_hit;

   assign in_win = ((regnum >= W0L) && (regnum <= W0H)) ||
                   ((regnum >= W1L) && (regnum <= W1H));

   generate
      if (IMPL_COUNT > 0) begin : g_impl
         localparam logic [REG_W-1:0] IL = REG_W'(IMPL_LO);
         localparam logic [REG_W-1:0] IH = REG_W'(IMPL_LO + IMPL_COUNT - 1);
         assign impl_hit = (regnum >= IL) && (regnum <= IH);
      end else begin : g_no_impl
         assign impl_hit = 1'b0;
      end
   endgenerate

   always_comb begin
      if (baseline || !in_win) cls = CLS_PLAIN;
      else if (impl_hit)       cls = CLS_IMPL;
      else                     cls = CLS_RSVD;
   end

endmodule

// File: rtl/dbgf_arbiter.sv
module dbgf_arbiter #(
   parameter int N = 3
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] valid,
   output logic [N-1:0] ready,
   output logic [N-1:0] grant
);

   // busy[i] is high when some port ranked above i is requesting
   logic [N:0] busy;
   assign busy[0] = 1'b0;

   generate
      for (genvar gi = 0; gi < N; gi++) begin : g_rank
         assign ready[gi]  = ~busy[gi];
         assign grant[gi]  = valid[gi] & ~busy[gi];
         assign busy[gi+1] = busy[gi] | valid[gi];
      end
   endgenerate

   assert_single_grant_R11: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(grant));

   assert_grant_needs_valid_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (grant & ~valid) == '0);

   assert_top_rank_wins_R11: assert property (@(posedge clk) disable iff (!rst_n)
      valid[0] |-> grant[0]);

endmodule

// File: rtl/dbgf_policy.sv
module dbgf_policy
   import dbgf_pkg::*;
#(
   parameter bit EXT_FWD_LOCKED = 1'b1
) (
   input  logic [1:0] port_sel,
   input  logic       pwr_down,
   input  logic       sw_en,
   input  reg_cls_e   cls,
   output act_e       act,
   output rsp_e       status
);

   logic ext_blocked;
   logic locked_out;

   generate
      if (EXT_FWD_LOCKED) begin : g_ext_pass
         assign ext_blocked = 1'b0;
      end else begin : g_ext_block
         assign ext_blocked = 1'b1;
      end
   endgenerate

   assign locked_out = (cls != CLS_PLAIN) && !sw_en &&
                       ((port_sel != PORT_EXT) || ext_blocked);

   always_comb begin
      act    = ACT_FWD;
      status = RSP_OK;
      if (pwr_down) begin
         act    = ACT_FAIL;
         status = RSP_ERR;
      end else if (locked_out) begin
         act    = ACT_FAIL;
         status = (port_sel == PORT_CP) ? RSP_UNDEF : RSP_ERR;
      end else if (cls == CLS_RSVD) begin
         act    = ACT_ZERO;
         status = RSP_OK;
      end
   end

endmodule

// File: rtl/dbg_access_filter.sv
module dbg_access_filter
   import dbgf_pkg::*;
#(
   parameter int REG_W          = 10,
   parameter int DATA_W         = 32,
   parameter int WIN0_LO        = 512,
   parameter int WIN0_HI        = 575,
   parameter int WIN1_LO        = 928,
   parameter int WIN1_HI        = 959,
   parameter int IMPL_LO        = 512,
   parameter int IMPL_COUNT     = 4,
   parameter bit EXT_FWD_LOCKED = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              dbg_pwr_on,
   input  logic              core_pwr_on,
   input  logic              single_domain,
   input  logic              sw_access_en,
   input  logic              baseline_cp,
   input  logic              ext_req_valid,
   output logic              ext_req_ready,
   input  logic [REG_W-1:0]  ext_req_regnum,
   input  logic              ext_req_write,
   input  logic [DATA_W-1:0] ext_req_wdata,
   output logic              ext_rsp_valid,
   output logic [1:0]        ext_rsp_status,
   output logic [DATA_W-1:0] ext_rsp_rdata,
   input  logic              cp_req_valid,
   output logic              cp_req_ready,
   input  logic [REG_W-1:0]  cp_req_regnum,
   input  logic              cp_req_write,
   input  logic [DATA_W-1:0] cp_req_wdata,
   output logic              cp_rsp_valid,
   output logic [1:0]        cp_rsp_status,
   output logic [DATA_W-1:0] cp_rsp_rdata,
   input  logic              mm_req_valid,
   output logic              mm_req_ready,
   input  logic [REG_W-1:0]  mm_req_regnum,
   input  logic              mm_req_write,
   input  logic [DATA_W-1:0] mm_req_wdata,
   output logic              mm_rsp_valid,
   output logic [1:0]        mm_rsp_status,
   output logic [DATA_W-1:0] mm_rsp_rdata,
   output logic              bank_valid,
   output logic [REG_W-1:0]  bank_regnum,
   output logic              bank_write,
   output logic [DATA_W-1:0] bank_wdata,
   input  logic [DATA_W-1:0] bank_rdata
);

   localparam int NP = NUM_PORTS;

   // elaboration-time parameter checks
   generate
      if (REG_W < 10 || REG_W > 16) begin : g_bad_regw
         $error("REG_W must lie in 10..16");
      end
      if (WIN0_LO > WIN0_HI || WIN1_LO > WIN1_HI || WIN1_HI >= (1 << REG_W)) begin : g_bad_win
         $error("window bounds out of order or out of range");
      end
      if (IMPL_COUNT < 0 || (IMPL_COUNT > 0 && (IMPL_LO < WIN0_LO ||
          IMPL_LO + IMPL_COUNT - 1 > WIN0_HI))) begin : g_bad_impl
         $error("implemented range must sit inside the first window");
      end
   endgenerate

   // gather per-port request fields into arrays, ext/cp/mm by rank
   logic [NP-1:0]     rq_valid;
   logic [REG_W-1:0]  rq_regnum [NP];
   logic [NP-1:0]     rq_write;
   logic [DATA_W-1:0] rq_wdata  [NP];
   logic [NP-1:0]     rq_ready;
   logic [NP-1:0]     grant;

   assign rq_valid  = {mm_req_valid, cp_req_valid, ext_req_valid};
   assign rq_write  = {mm_req_write, cp_req_write, ext_req_write};
   assign rq_regnum[PORT_EXT] = ext_req_regnum;
   assign rq_regnum[PORT_CP]  = cp_req_regnum;
   assign rq_regnum[PORT_MM]  = mm_req_regnum;
   assign rq_wdata[PORT_EXT]  = ext_req_wdata;
   assign rq_wdata[PORT_CP]   = cp_req_wdata;
   assign rq_wdata[PORT_MM]   = mm_req_wdata;

   dbgf_arbiter #(.N(NP)) u_arb (
      .clk   (clk),
      .rst_n (rst_n),
      .valid (rq_valid),
      .ready (rq_ready),
      .grant (grant)
   );

   assign ext_req_ready = rq_ready[PORT_EXT];
   assign cp_req_ready  = rq_ready[PORT_CP];
   assign mm_req_ready  = rq_ready[PORT_MM];

   // one-hot select of the winning request
   logic [REG_W-1:0]  sel_regnum;
   logic              sel_write;
   logic [DATA_W-1:0] sel_wdata;
   logic [1:0]        sel_port;
   logic              any_grant;

   always_comb begin
      sel_regnum = '0;
      sel_write  = 1'b0;
      sel_wdata  = '0;
      sel_port   = PORT_EXT;
      for (int i = 0; i < NP; i++) begin
         if (grant[i]) begin
            sel_regnum = rq_regnum[i];
            sel_write  = rq_write[i];
            sel_wdata  = rq_wdata[i];
            sel_port   = 2'(i);
         end
      end
   end

   assign any_grant = |grant;

   // power state
   logic pwr_down;
   assign pwr_down = single_domain ? !core_pwr_on : !dbg_pwr_on;

   reg_cls_e cls;
   act_e     act;
   rsp_e     status;

   dbgf_classify #(
      .REG_W      (REG_W),
      .WIN0_LO    (WIN0_LO),
      .WIN0_HI    (WIN0_HI),
      .WIN1_LO    (WIN1_LO),
      .WIN1_HI    (WIN1_HI),
      .IMPL_LO    (IMPL_LO),
      .IMPL_COUNT (IMPL_COUNT)
   ) u_cls (
      .regnum   (sel_regnum),
      .baseline (baseline_cp),
      .cls      (cls)
   );

   dbgf_policy #(.EXT_FWD_LOCKED(EXT_FWD_LOCKED)) u_pol (
      .port_sel (sel_port),
      .pwr_down (pwr_down),
      .sw_en    (sw_access_en),
      .cls      (cls),
      .act      (act),
      .status   (status)
   );

   // bank side
   assign bank_valid  = any_grant && (act == ACT_FWD);
   assign bank_regnum = sel_regnum;
   assign bank_write  = sel_write;
   assign bank_wdata  = sel_wdata;

   // shared response register: at most one response per cycle
   logic [NP-1:0]     rsp_vld_q;
   logic [1:0]        rsp_st_q;
   logic [DATA_W-1:0] rsp_rd_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsp_vld_q <= '0;
         rsp_st_q  <= RSP_OK;
         rsp_rd_q  <= '0;
      end else begin
         rsp_vld_q <= grant;
         if (any_grant) begin
            rsp_st_q <= status;
            rsp_rd_q <= (act == ACT_FWD && !sel_write) ? bank_rdata : '0;
         end
      end
   end

   assign ext_rsp_valid  = rsp_vld_q[PORT_EXT];
   assign cp_rsp_valid   = rsp_vld_q[PORT_CP];
   assign mm_rsp_valid   = rsp_vld_q[PORT_MM];
   assign ext_rsp_status = rsp_st_q;
   assign cp_rsp_status  = rsp_st_q;
   assign mm_rsp_status  = rsp_st_q;
   assign ext_rsp_rdata  = rsp_rd_q;
   assign cp_rsp_rdata   = rsp_rd_q;
   assign mm_rsp_rdata   = rsp_rd_q;

   // response timing per port
   generate
      for (genvar gp = 0; gp < NP; gp++) begin : g_rsp_chk
         assert_rsp_next_cycle_R10: assert property (@(posedge clk) disable iff (!rst_n)
            (rq_valid[gp] && rq_ready[gp]) |=> rsp_vld_q[gp]);
         assert_rsp_single_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
            (rsp_vld_q[gp] && !(rq_valid[gp] && rq_ready[gp])) |=> !rsp_vld_q[gp]);
      end
   endgenerate

   assert_pd_error_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (any_grant && (single_domain ? !core_pwr_on : !dbg_pwr_on)) |=> rsp_st_q == RSP_ERR);

   assert_pd_no_fwd_R2: assert property (@(posedge clk) disable iff (!rst_n)
      bank_valid |-> (single_domain ? core_pwr_on : dbg_pwr_on));

   assert_cp_undef_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (cp_req_valid && cp_req_ready && !pwr_down && !sw_access_en &&
       cls != CLS_PLAIN) |=> (cp_rsp_valid && cp_rsp_status == RSP_UNDEF));

   assert_mm_locked_err_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (mm_req_valid && mm_req_ready && !sw_access_en && cls != CLS_PLAIN)
      |=> (mm_rsp_valid && mm_rsp_status == RSP_ERR));

   assert_rsvd_never_fwd_R8: assert property (@(posedge clk) disable iff (!rst_n)
      bank_valid |-> cls != CLS_RSVD);

   assert_baseline_ok_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (any_grant && baseline_cp && !pwr_down) |=> rsp_st_q == RSP_OK);

endmodule

// File: tb/tb_dbg_access_filter.sv
`timescale 1ns/1ps
module tb_dbg_access_filter;

   localparam int RW = 10;
   localparam int DW = 32;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #4 clk = ~clk;   // 125 MHz

   logic dbg_pwr_on, core_pwr_on, single_domain, sw_access_en, baseline_cp;
   logic ext_req_valid, ext_req_ready, ext_req_write, ext_rsp_valid;
   logic cp_req_valid, cp_req_ready, cp_req_write, cp_rsp_valid;
   logic mm_req_valid, mm_req_ready, mm_req_write, mm_rsp_valid;
   logic [RW-1:0] ext_req_regnum, cp_req_regnum, mm_req_regnum, bank_regnum;
   logic [DW-1:0] ext_req_wdata, cp_req_wdata, mm_req_wdata, bank_wdata, bank_rdata;
   logic [DW-1:0] ext_rsp_rdata, cp_rsp_rdata, mm_rsp_rdata;
   logic [1:0]    ext_rsp_status, cp_rsp_status, mm_rsp_status;
   logic          bank_valid, bank_write;

   // bank model: read data derived from register number
   assign bank_rdata = 32'hC3C3_0000 ^ {22'd0, bank_regnum};

   dbg_access_filter dut (
      .clk(clk), .rst_n(rst_n),
      .dbg_pwr_on(dbg_pwr_on), .core_pwr_on(core_pwr_on),
      .single_domain(single_domain), .sw_access_en(sw_access_en),
      .baseline_cp(baseline_cp),
      .ext_req_valid(ext_req_valid), .ext_req_ready(ext_req_ready),
      .ext_req_regnum(ext_req_regnum), .ext_req_write(ext_req_write),
      .ext_req_wdata(ext_req_wdata), .ext_rsp_valid(ext_rsp_valid),
      .ext_rsp_status(ext_rsp_status), .ext_rsp_rdata(ext_rsp_rdata),
      .cp_req_valid(cp_req_valid), .cp_req_ready(cp_req_ready),
      .cp_req_regnum(cp_req_regnum), .cp_req_write(cp_req_write),
      .cp_req_wdata(cp_req_wdata), .cp_rsp_valid(cp_rsp_valid),
      .cp_rsp_status(cp_rsp_status), .cp_rsp_rdata(cp_rsp_rdata),
      .mm_req_valid(mm_req_valid), .mm_req_ready(mm_req_ready),
      .mm_req_regnum(mm_req_regnum), .mm_req_write(mm_req_write),
      .mm_req_wdata(mm_req_wdata), .mm_rsp_valid(mm_rsp_valid),
      .mm_rsp_status(mm_rsp_status), .mm_rsp_rdata(mm_rsp_rdata),
      .bank_valid(bank_valid), .bank_regnum(bank_regnum),
      .bank_write(bank_write), .bank_wdata(bank_wdata),
      .bank_rdata(bank_rdata)
   );

   typedef struct {
      logic [1:0]  st;
      logic [31:0] rd;
      bit          care;
      string       req;
   } exp_t;

   exp_t q_ext[$];
   exp_t q_cp[$];
   exp_t q_mm[$];

   int checks = 0;
   int errors = 0;
   bit finished = 1'b0;

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   // reference model built from the requirements
   function automatic int reg_class(input int r, input bit base);
      if (base) return 0;
      if ((r >= 512 && r <= 575) || (r >= 928 && r <= 959))
         return (r >= 512 && r <= 515) ? 1 : 2;   // R3
      return 0;
   endfunction

   task automatic model(input int p, input bit sd, input bit dp, input bit cp_on,
                        input bit sw, input bit base, input int r, input bit w,
                        output bit fwd, output logic [1:0] st, output logic [31:0] rd,
                        output bit care, output string req);
      bit pd;
      int c;
      pd   = sd ? !cp_on : !dp;                       // R1
      c    = reg_class(r, base);
      fwd  = 1'b0; st = 2'b00; rd = 32'h0; care = 1'b1;
      if (pd) begin
         st = 2'b01; care = (p != 1); req = "R1/R2";
         return;
      end
      if (c != 0 && !sw && p != 0) begin
         st  = (p == 1) ? 2'b10 : 2'b01;
         req = (p == 1) ? "R5" : "R4";
         return;
      end
      if (c == 2) begin
         req = (!sw && p == 0) ? "R6/R8" : "R8";
         return;
      end
      fwd = 1'b1;
      rd  = w ? 32'h0 : (32'hC3C3_0000 ^ r);
      req = base ? "R7/R9" : ((!sw && p == 0 && c == 1) ? "R6/R9" : "R9");
   endtask

   task automatic set_port(input int p, input bit v, input int r, input bit w,
                           input logic [31:0] d);
      case (p)
         0: begin ext_req_valid = v; ext_req_regnum = RW'(r); ext_req_write = w; ext_req_wdata = d; end
         1: begin cp_req_valid  = v; cp_req_regnum  = RW'(r); cp_req_write  = w; cp_req_wdata  = d; end
         default: begin mm_req_valid = v; mm_req_regnum = RW'(r); mm_req_write = w; mm_req_wdata = d; end
      endcase
   endtask

   function automatic bit port_ready(input int p);
      case (p)
         0: return ext_req_ready;
         1: return cp_req_ready;
         default: return mm_req_ready;
      endcase
   endfunction

   task automatic push(input int p, input exp_t e);
      case (p)
         0: q_ext.push_back(e);
         1: q_cp.push_back(e);
         default: q_mm.push_back(e);
      endcase
   endtask

   // checks bank side in the accept cycle and queues the response
   task automatic expect_accept(input int p, input int r, input bit w, input logic [31:0] d);
      bit fwd, care;
      logic [1:0] st;
      logic [31:0] rd;
      string req;
      exp_t e;
      model(p, single_domain, dbg_pwr_on, core_pwr_on, sw_access_en, baseline_cp,
            r, w, fwd, st, rd, care, req);
      chk(port_ready(p) == 1'b1, "R11", "ready", 32'(port_ready(p)), 32'h1);
      chk(bank_valid == fwd, req, "bank_valid", 32'(bank_valid), 32'(fwd));
      if (fwd) begin
         chk(bank_regnum == RW'(r) && bank_write == w && bank_wdata == d, "R9",
             "bank fields", {bank_write, 21'd0, bank_regnum}, {w, 21'd0, RW'(r)});
      end
      e.st = st; e.rd = rd; e.care = care; e.req = req;
      push(p, e);
   endtask

   task automatic do_access(input int p, input int r, input bit w);
      logic [31:0] d;
      d = 32'h1000_0000 + 32'(r);
      @(negedge clk);
      set_port(p, 1'b1, r, w, d);
      #1;
      expect_accept(p, r, w, d);
      @(posedge clk);
      #1;
      set_port(p, 1'b0, 0, 1'b0, 32'h0);
   endtask

   // monitor: compares responses with the scoreboard at negedge
   task automatic pop_cmp(input string nm, input logic [1:0] st, input logic [31:0] rd,
                          ref exp_t q[$]);
      exp_t e;
      if (q.size() == 0) begin
         chk(1'b0, "R10", {nm, " unexpected response"}, 32'h1, 32'h0);
         return;
      end
      e = q.pop_front();
      if (e.care) begin
         chk(st == e.st, {e.req, "/R10"}, {nm, " status"}, 32'(st), 32'(e.st));
         chk(rd == e.rd, e.req, {nm, " rdata"}, rd, e.rd);
      end
   endtask

   always @(negedge clk) begin
      if (rst_n) begin
         if (ext_rsp_valid) pop_cmp("ext", ext_rsp_status, ext_rsp_rdata, q_ext);
         if (cp_rsp_valid)  pop_cmp("cp",  cp_rsp_status,  cp_rsp_rdata,  q_cp);
         if (mm_rsp_valid)  pop_cmp("mm",  mm_rsp_status,  mm_rsp_rdata,  q_mm);
      end
   end

   task automatic drain();
      repeat (3) @(negedge clk);
      chk(q_ext.size() == 0 && q_cp.size() == 0 && q_mm.size() == 0, "R10",
          "responses outstanding", 32'(q_ext.size() + q_cp.size() + q_mm.size()), 32'h0);
   endtask

   int regs[13] = '{5, 511, 512, 514, 515, 516, 575, 576, 927, 928, 959, 960, 1023};

   initial begin
      dbg_pwr_on = 1; core_pwr_on = 1; single_domain = 0; sw_access_en = 1; baseline_cp = 0;
      for (int p = 0; p < 3; p++) set_port(p, 1'b0, 0, 1'b0, 32'h0);
      repeat (3) @(posedge clk);
      #1;
      chk(!ext_rsp_valid && !cp_rsp_valid && !mm_rsp_valid, "R10", "reset rsp_valid",
          {29'd0, ext_rsp_valid, cp_rsp_valid, mm_rsp_valid}, 32'h0);
      chk(ext_rsp_status == 2'b00 && ext_rsp_rdata == 32'h0, "R10", "reset status",
          {30'd0, ext_rsp_status}, 32'h0);
      rst_n = 1'b1;

      // full sweep: R1..R9
      for (int cfg = 0; cfg < 8; cfg++) begin
         for (int sw = 0; sw < 2; sw++) begin
            for (int base = 0; base < 2; base++) begin
               @(negedge clk);
               single_domain = cfg[2]; dbg_pwr_on = cfg[1]; core_pwr_on = cfg[0];
               sw_access_en = sw[0]; baseline_cp = base[0];
               for (int p = 0; p < 3; p++) begin
                  for (int ri = 0; ri < 13; ri++) begin
                     do_access(p, regs[ri], 1'b0);
                     do_access(p, regs[ri], 1'b1);
                  end
               end
            end
         end
      end
      drain();

      // contention: R11
      @(negedge clk);
      dbg_pwr_on = 1; core_pwr_on = 1; single_domain = 0; sw_access_en = 1; baseline_cp = 0;
      set_port(0, 1'b1, 10, 1'b0, 32'h0);
      set_port(1, 1'b1, 20, 1'b0, 32'h0);
      set_port(2, 1'b1, 30, 1'b0, 32'h0);
      #1;
      chk(!cp_req_ready && !mm_req_ready, "R11", "lower ranks held",
          {30'd0, cp_req_ready, mm_req_ready}, 32'h0);
      expect_accept(0, 10, 1'b0, 32'h0);
      @(posedge clk); #1; set_port(0, 1'b0, 0, 1'b0, 32'h0);
      @(negedge clk); #1;
      chk(!mm_req_ready, "R11", "mm held behind cp", 32'(mm_req_ready), 32'h0);
      expect_accept(1, 20, 1'b0, 32'h0);
      @(posedge clk); #1; set_port(1, 1'b0, 0, 1'b0, 32'h0);
      @(negedge clk); #1;
      expect_accept(2, 30, 1'b0, 32'h0);
      @(posedge clk); #1; set_port(2, 1'b0, 0, 1'b0, 32'h0);
      drain();

      // cp and mm together: cp first
      @(negedge clk);
      set_port(1, 1'b1, 40, 1'b1, 32'hABCD);
      set_port(2, 1'b1, 41, 1'b0, 32'h0);
      #1;
      chk(!mm_req_ready, "R11", "mm held behind cp pair", 32'(mm_req_ready), 32'h0);
      expect_accept(1, 40, 1'b1, 32'hABCD);
      @(posedge clk); #1; set_port(1, 1'b0, 0, 1'b0, 32'h0);
      @(negedge clk); #1;
      expect_accept(2, 41, 1'b0, 32'h0);
      @(posedge clk); #1; set_port(2, 1'b0, 0, 1'b0, 32'h0);
      drain();

      // sampling at acceptance: R12
      @(negedge clk);
      sw_access_en = 1;
      set_port(1, 1'b1, 512, 1'b0, 32'h0);
      #1;
      expect_accept(1, 512, 1'b0, 32'h0);
      @(posedge clk); #1;
      sw_access_en = 0; dbg_pwr_on = 0;
      set_port(1, 1'b0, 0, 1'b0, 32'h0);
      drain();
      chk(1'b1, "R12", "late input change ignored", 32'h0, 32'h0);

      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      #(200000 * 8);
      if (!finished) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

endmodule